// File: doc/BRIEF.md
# Two-Slot Elastic Buffer

This block replaces an ordinary pipeline register in a latency-insensitive design. Each side has a channel made of a forward valid, a backward stall and a data word. A word moves across a channel in any cycle where valid is high and stall is low. When valid is low, the channel is idle. When valid and stall are both high, the channel is in retry. In retry the sender keeps the same word on the channel, and it may not drop valid until the word has been taken.

The buffer has two storage stages, a head and a tail, so it holds up to two tokens. Its occupancy is shown directly by its own control outputs:
- Empty (a bubble): output valid low and input stall low.
- Half: output valid high and input stall low.
- Full: output valid high and input stall high.

Tokens leave in the order they arrived. A parameter chooses the starting occupancy (empty, half or full). Two more parameters give the words preloaded at reset.

Top module: `elastic_pair_buf`

## Requirements
- R1: With the default configuration, the cycle after a synchronous reset shows output valid 0 and input stall 0 (empty).
- R2: From empty, one accepted word gives output valid 1, input stall 0 and that word on the output data (half).
- R3: From half, an accepted word with no output transfer gives output valid 1 and input stall 1 (full). The older word stays on the output data.
- R4: A word is accepted only when input valid is 1 and input stall is 0. A word presented while input stall is 1 is never stored. The bench checks this by draining the buffer: that word never appears on the output.
- R5: While output valid is 1 and output stall is 1, the next cycle keeps output valid at 1 and output data unchanged.
- R6: Words leave in arrival order. When a full buffer makes an output transfer, the newer word moves to the output data and the state becomes half.
- R7: An input transfer and an output transfer in the same cycle, in the half state, keep the buffer half. The new word then appears on the output data.
- R8: Output stall asserted while the buffer is empty does not block input. A word offered in that state is accepted and appears one cycle later.
- R9: The parameter INIT_OCC (0 = empty, 1 = half, 2 = full) sets the state after reset. The head preload INIT_HEAD is presented first. The tail preload INIT_TAIL follows it after one output transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream word is valid |
| in_data | input | W | Upstream word |
| in_stall | output | 1 | Buffer cannot take a word (full) |
| out_valid | output | 1 | Buffer presents a word (half or full) |
| out_data | output | W | Oldest stored word |
| out_stall | input | 1 | Downstream cannot take the word |

## Verification
Every output of the buffer comes from a register. So the result of an input pattern is due exactly one rising edge after it is applied. The bench drives a new pattern at each falling edge. It then samples the outputs at the next falling edge, after the single rising edge in between. The drain checks for arrival order and for the ignored stalled word rely on this one-cycle latency. Each step of those checks expects the next queued word.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;

    // Encoding is {in_stall, out_valid}: the state bits are the channel outputs.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'b00,
        OCC_HALF  = 2'b01,
        OCC_FULL  = 2'b11
    } occ_e;

    typedef struct packed {
        occ_e occ;
    } ctrl_st_t;

    function automatic occ_e occ_from_count(input int n);
        occ_e r;
        case (n)
            1:       r = OCC_HALF;
            2:       r = OCC_FULL;
            default: r = OCC_EMPTY;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ebuf_ctrl.sv
module ebuf_ctrl
    import ebuf_pkg::*;
#(
    parameter int INIT_OCC = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_stall,
    output logic out_valid,
    output logic in_stall,
    output logic load_head,
    output logic load_tail,
    output logic head_from_tail
);

    localparam occ_e RST_OCC = occ_from_count(INIT_OCC);

    ctrl_st_t st_d, st_q;
    logic     in_xfer, out_xfer;

    assign out_valid = st_q.occ[0];
    assign in_stall  = st_q.occ[1];

    always_comb begin
        st_d           = st_q;
        load_head      = 1'b0;
        load_tail      = 1'b0;
        head_from_tail = 1'b0;
        in_xfer        = in_valid & ~in_stall;
        out_xfer       = out_valid & ~out_stall;
        case (st_q.occ)
            OCC_EMPTY: begin
                if (in_xfer) begin
                    load_head = 1'b1;
                    st_d.occ  = OCC_HALF;
                end
            end
            OCC_HALF: begin
                if (in_xfer && out_xfer) begin
                    load_head = 1'b1;
                end else if (in_xfer) begin
                    load_tail = 1'b1;
                    st_d.occ  = OCC_FULL;
                end else if (out_xfer) begin
                    st_d.occ  = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (out_xfer) begin
                    head_from_tail = 1'b1;
                    st_d.occ       = OCC_HALF;
                end
            end
            default: st_d.occ = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.occ <= RST_OCC;
        else     st_q     <= st_d;
    end

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_stall && out_stall) |=> (in_stall && out_valid));

    // R8
    empty_open_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !in_stall);

endmodule

// File: rtl/ebuf_slots.sv
module ebuf_slots #(
    parameter int          W         = 8,
    parameter logic [W-1:0] INIT_HEAD = '0,
    parameter logic [W-1:0] INIT_TAIL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_data,
    input  logic         load_head,
    input  logic         load_tail,
    input  logic         head_from_tail,
    output logic [W-1:0] head,
    output logic [W-1:0] tail
);

    typedef struct packed {
        logic [W-1:0] head;
        logic [W-1:0] tail;
    } slot_st_t;

    slot_st_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        if (load_head)      sl_d.head = in_data;
        if (head_from_tail) sl_d.head = sl_q.tail;
        if (load_tail)      sl_d.tail = in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sl_q.head <= INIT_HEAD;
            sl_q.tail <= INIT_TAIL;
        end else begin
            sl_q <= sl_d;
        end
    end

    assign head = sl_q.head;
    assign tail = sl_q.tail;

    // R6
    one_write_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({load_head, head_from_tail, load_tail}) <= 1);

endmodule

// File: rtl/elastic_pair_buf.sv
module elastic_pair_buf #(
    parameter int           W         = 8,
    parameter int           INIT_OCC  = 0,
    parameter logic [W-1:0] INIT_HEAD = '0,
    parameter logic [W-1:0] INIT_TAIL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_stall,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_stall
);

    logic         load_head, load_tail, head_from_tail;
    logic [W-1:0] tail;

    ebuf_ctrl #(.INIT_OCC(INIT_OCC)) ctrl_i (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .out_stall      (out_stall),
        .out_valid      (out_valid),
        .in_stall       (in_stall),
        .load_head      (load_head),
        .load_tail      (load_tail),
        .head_from_tail (head_from_tail)
    );

    ebuf_slots #(.W(W), .INIT_HEAD(INIT_HEAD), .INIT_TAIL(INIT_TAIL)) slots_i (
        .clk            (clk),
        .rst            (rst),
        .in_data        (in_data),
        .load_head      (load_head),
        .load_tail      (load_tail),
        .head_from_tail (head_from_tail),
        .head           (out_data),
        .tail           (tail)
    );

    // R5
    retry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_stall) |=> (out_valid && $stable(out_data)));

    // R6
    order_chk: assert property (@(posedge clk) disable iff (rst)
        (in_stall && !out_stall) |=> (out_valid && !in_stall && out_data == $past(tail)));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_stall) |=> out_valid);

endmodule

// File: tb/elastic_pair_buf_tb_top.sv
`timescale 1ns/1ps
module elastic_pair_buf_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_stall = 1'b0;
    logic       in_stall, out_valid;
    logic [7:0] out_data;
    logic       p_stall = 1'b1;
    logic       h_is, h_ov, f_is, f_ov;
    logic [7:0] h_od, f_od;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    elastic_pair_buf #(.W(8)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_stall(in_stall), .out_valid(out_valid), .out_data(out_data),
        .out_stall(out_stall)
    );

    elastic_pair_buf #(.W(8), .INIT_OCC(1), .INIT_HEAD(8'h5A)) dut_half_i (
        .clk(clk), .rst(rst), .in_valid(1'b0), .in_data(8'h00),
        .in_stall(h_is), .out_valid(h_ov), .out_data(h_od), .out_stall(p_stall)
    );

    elastic_pair_buf #(.W(8), .INIT_OCC(2), .INIT_HEAD(8'h11), .INIT_TAIL(8'h22)) dut_full_i (
        .clk(clk), .rst(rst), .in_valid(1'b0), .in_data(8'h00),
        .in_stall(f_is), .out_valid(f_ov), .out_data(f_od), .out_stall(p_stall)
    );

    typedef struct packed {
        logic       iv;
        logic [7:0] d;
        logic       os;
        logic       eov;
        logic       eis;
        logic       dchk;
        logic [7:0] ed;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'hA1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA1, 4'd8},
        '{1'b1, 8'hB2, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA1, 4'd3},
        '{1'b1, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA1, 4'd5},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'hB2, 4'd6},
        '{1'b1, 8'hD4, 1'b0, 1'b1, 1'b0, 1'b1, 8'hD4, 4'd7},
        '{1'b1, 8'hE5, 1'b0, 1'b1, 1'b0, 1'b1, 8'hE5, 4'd7},
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'hE5, 4'd5},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd4},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2}
    };

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 default reset state
        check("R1", "out_valid", {7'b0, out_valid}, 8'h00);
        check("R1", "in_stall",  {7'b0, in_stall},  8'h00);
        // R9 preloaded instances
        check("R9", "half out_valid", {7'b0, h_ov}, 8'h01);
        check("R9", "half in_stall",  {7'b0, h_is}, 8'h00);
        check("R9", "half out_data",  h_od, 8'h5A);
        check("R9", "full out_valid", {7'b0, f_ov}, 8'h01);
        check("R9", "full in_stall",  {7'b0, f_is}, 8'h01);
        check("R9", "full head",      f_od, 8'h11);

        // Vector walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            in_valid  = VEC[i].iv;
            in_data   = VEC[i].d;
            out_stall = VEC[i].os;
            @(negedge clk);
            check(tag, $sformatf("vec%0d out_valid", i), {7'b0, out_valid}, {7'b0, VEC[i].eov});
            check(tag, $sformatf("vec%0d in_stall", i),  {7'b0, in_stall},  {7'b0, VEC[i].eis});
            if (VEC[i].dchk)
                check(tag, $sformatf("vec%0d out_data", i), out_data, VEC[i].ed);
        end

        // R2 from empty, single word without stall
        in_valid = 1'b1; in_data = 8'h3C; out_stall = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "single out_valid", {7'b0, out_valid}, 8'h01);
        check("R2", "single out_data",  out_data, 8'h3C);
        out_stall = 1'b0;
        @(negedge clk);
        check("R2", "drained out_valid", {7'b0, out_valid}, 8'h00);

        // R9 full preload drains head then tail; half preload drains once
        p_stall = 1'b0;
        @(negedge clk);
        check("R9", "full second word", f_od, 8'h22);
        check("R9", "full now half",    {7'b0, f_is}, 8'h00);
        check("R9", "half emptied",     {7'b0, h_ov}, 8'h00);
        @(negedge clk);
        check("R9", "full emptied",     {7'b0, f_ov}, 8'h00);

        // R1 reset again from a non-empty state
        in_valid = 1'b1; in_data = 8'h77; out_stall = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "re-reset out_valid", {7'b0, out_valid}, 8'h00);
        check("R1", "re-reset in_stall",  {7'b0, in_stall},  8'h00);

        finish_run();
    end

endmodule